// File: doc/BRIEF.md
# Conversion Timing Generator

This block sequences a converter that samples continuously. It derives no analog behaviour and captures no data. From the system clock it builds a converter-rate enable (`adc_tick`) using a programmable divide ratio. It then groups those ticks into conversion frames of 26 or 32 ticks. Each frame opens with a settling window of 4 or 10 ticks, shown on `settling`. A one-cycle `eoc` strobe marks the final tick of each frame.

While `run` stays high, frames follow one another with no gap, so one sample appears every ratio × frame-length system clocks. The divide ratio and the stretch select are sampled only when a frame begins. A value written during a frame therefore shapes the next frame and never the current one. When `run` drops, the frame in progress runs to its end and the block then rests with every output low.

Top module: `conv_timing_gen`

## Requirements
- R1: With an effective ratio N, `adc_tick` is high for exactly one system cycle in every N, and a frame of L ticks lasts exactly N×L system cycles.
- R2: A programmed ratio of 0 or 1 behaves exactly like a ratio of 2, so two `adc_tick` pulses are never in adjacent cycles.
- R3: With `long_settle` low at frame start, a frame holds 26 ticks.
- R4: With `long_settle` high at frame start, a frame holds 32 ticks.
- R5: `settling` is high from the first cycle of a frame for 4×N system cycles, or for 10×N system cycles in a stretched frame, and is low when `eoc` fires.
- R6: `eoc` is a single-cycle pulse that coincides with the last `adc_tick` of the frame.
- R7: While `run` stays high, the next frame begins in the cycle right after `eoc`, and `settling` is high in that cycle.
- R8: `div_ratio` and `long_settle` are sampled only when a frame starts. A change made mid-frame alters neither that frame's length nor its tick count.
- R9: When `run` is low in the `eoc` cycle, no further frame starts and `adc_tick`, `settling` and `eoc` all stay low.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| div_ratio | input | 8 | System clocks per converter tick; 0 and 1 are taken as 2 |
| long_settle | input | 1 | Selects the 32-tick frame with a 10-tick settling window |
| run | input | 1 | Keeps frames running back to back; sampled at each frame boundary |
| adc_tick | output | 1 | One-cycle converter clock enable |
| settling | output | 1 | High during the settling window at the start of a frame |
| eoc | output | 1 | One-cycle end-of-conversion strobe on the final tick |

## Verification
The end of one frame and the reload of the configuration for the next fall in the same cycle. The `eoc` cycle both closes the running frame and samples `div_ratio` and `long_settle` for the following one. The bench holds `run` high and changes the ratio and the stretch bit in the middle of a frame. It judges the result by the exact `eoc` cycle, the tick count and the settling length of the unchanged frame and of the frames that follow. A one-cycle `run` pulse and a mid-frame drop of `run` provoke the same boundary with a halt in place of a reload.

// File: rtl/conv_timing_pkg.sv
package conv_timing_pkg;
    localparam int CT_RATIO_W      = 8;
    localparam int CT_RATIO_MIN    = 2;
    localparam int CT_FRAME_SHORT  = 26;
    localparam int CT_FRAME_LONG   = 32;
    localparam int CT_SETTLE_SHORT = 4;
    localparam int CT_SETTLE_LONG  = 10;
endpackage

// File: rtl/ct_cfg_latch.sv
// Holds the clamped ratio and stretch select for the frame in progress.
module ct_cfg_latch #(
    parameter int RATIO_W   = 8,
    parameter int RATIO_MIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               long_in,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               long_q
);
    localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(RATIO_MIN);

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               long_sel;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.ratio    = (ratio_in < MIN_V) ? MIN_V : ratio_in;
            s_d.long_sel = long_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ratio: MIN_V, long_sel: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio_q = s_q.ratio;
    assign long_q  = s_q.long_sel;
endmodule

// File: rtl/ct_clk_div.sv
// Divides the system clock into a one-cycle converter tick.
module ct_clk_div #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } div_t;

    div_t s_d, s_q;

    assign tick = en && (s_q.cnt == (ratio - ONE));

    always_comb begin
        s_d = s_q;
        if (!en || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ct_frame_seq.sv
// Counts ticks within a frame and decides start, settling and end of conversion.
module ct_frame_seq #(
    parameter int CYC_W        = 5,
    parameter int FRAME_SHORT  = 26,
    parameter int FRAME_LONG   = 32,
    parameter int SETTLE_SHORT = 4,
    parameter int SETTLE_LONG  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic long_sel,
    output logic active,
    output logic load,
    output logic settling,
    output logic eoc
);
    localparam logic [CYC_W-1:0] LAST_S = CYC_W'(FRAME_SHORT - 1);
    localparam logic [CYC_W-1:0] LAST_L = CYC_W'(FRAME_LONG - 1);
    localparam logic [CYC_W-1:0] SET_S  = CYC_W'(SETTLE_SHORT);
    localparam logic [CYC_W-1:0] SET_L  = CYC_W'(SETTLE_LONG);
    localparam logic [CYC_W-1:0] ONE    = CYC_W'(1);

    typedef struct packed {
        logic             active;
        logic [CYC_W-1:0] cyc;
    } seq_t;

    seq_t s_d, s_q;
    logic [CYC_W-1:0] last_idx;
    logic [CYC_W-1:0] settle_lim;

    assign last_idx   = long_sel ? LAST_L : LAST_S;
    assign settle_lim = long_sel ? SET_L : SET_S;
    assign eoc        = s_q.active && tick && (s_q.cyc == last_idx);
    assign load       = run && (!s_q.active || eoc);
    assign settling   = s_q.active && (s_q.cyc < settle_lim);
    assign active     = s_q.active;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.active = 1'b1;
            s_d.cyc    = '0;
        end else if (eoc) begin
            s_d.active = 1'b0;
            s_d.cyc    = '0;
        end else if (tick) begin
            s_d.cyc    = s_q.cyc + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{active: 1'b0, cyc: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/conv_timing_gen.sv
module conv_timing_gen
    import conv_timing_pkg::*;
#(
    parameter int RATIO_W      = CT_RATIO_W,
    parameter int RATIO_MIN    = CT_RATIO_MIN,
    parameter int FRAME_SHORT  = CT_FRAME_SHORT,
    parameter int FRAME_LONG   = CT_FRAME_LONG,
    parameter int SETTLE_SHORT = CT_SETTLE_SHORT,
    parameter int SETTLE_LONG  = CT_SETTLE_LONG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] div_ratio,
    input  logic               long_settle,
    input  logic               run,
    output logic               adc_tick,
    output logic               settling,
    output logic               eoc
);
    localparam int CYC_W = $clog2(FRAME_LONG);

    logic               load;
    logic               active;
    logic [RATIO_W-1:0] ratio_cur;
    logic               long_cur;

    ct_cfg_latch #(
        .RATIO_W  (RATIO_W),
        .RATIO_MIN(RATIO_MIN)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ratio_in(div_ratio),
        .long_in (long_settle),
        .ratio_q (ratio_cur),
        .long_q  (long_cur)
    );

    ct_clk_div #(
        .RATIO_W(RATIO_W)
    ) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .ratio(ratio_cur),
        .tick (adc_tick)
    );

    ct_frame_seq #(
        .CYC_W       (CYC_W),
        .FRAME_SHORT (FRAME_SHORT),
        .FRAME_LONG  (FRAME_LONG),
        .SETTLE_SHORT(SETTLE_SHORT),
        .SETTLE_LONG (SETTLE_LONG)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (adc_tick),
        .long_sel(long_cur),
        .active  (active),
        .load    (load),
        .settling(settling),
        .eoc     (eoc)
    );
endmodule

// File: rtl/conv_timing_chk.sv
module conv_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic adc_tick,
    input logic settling,
    input logic eoc
);
    assert_eoc_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> adc_tick);

    assert_eoc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_tick |=> !adc_tick);

    assert_eoc_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> !settling);

    assert_restart_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && run) |=> settling);

    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !run) |=> !(adc_tick || settling || eoc));
endmodule

bind conv_timing_gen conv_timing_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .adc_tick(adc_tick),
    .settling(settling),
    .eoc     (eoc)
);

// File: tb/conv_timing_gen_tb_top.sv
module conv_timing_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_ratio = 8'd0;
    logic       long_settle = 1'b0;
    logic       run = 1'b0;
    logic       adc_tick, settling, eoc;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int next_t = 0;
    int prev_t = 0;
    int mon_ticks = 0;
    int mon_setl = 0;

    typedef struct {
        int    t;
        int    ticks;
        int    setl;
        string tag;
    } frame_exp_t;

    frame_exp_t exp_q[$];

    always #5 clk = ~clk;

    conv_timing_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_ratio  (div_ratio),
        .long_settle(long_settle),
        .run        (run),
        .adc_tick   (adc_tick),
        .settling   (settling),
        .eoc        (eoc)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int eff(input int r);
        return (r < 2) ? 2 : r;
    endfunction

    // Driver side: start a run with a fresh configuration.
    task automatic launch(input int r, input bit lg);
        @(negedge clk);
        div_ratio   = 8'(r);
        long_settle = lg;
        run         = 1'b1;
        next_t      = cyc;
    endtask

    // Driver side: predict one frame using the configuration valid at its start.
    task automatic push_frame(input int r, input bit lg, input string tag);
        frame_exp_t it;
        int len;
        len      = lg ? 32 : 26;
        prev_t   = next_t;
        next_t   = next_t + eff(r) * len;
        it.t     = next_t;
        it.ticks = len;
        it.setl  = (lg ? 10 : 4) * eff(r);
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Drop run once the last predicted frame has started.
    task automatic stop_after_current();
        wait_until(prev_t + 1);
        run = 1'b0;
    endtask

    task automatic drain_idle();
        int highs;
        highs = 0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) begin
            @(negedge clk);
            if (adc_tick || settling || eoc) highs++;
        end
        chk(highs == 0, "R9 idle after run drop", highs, 0);
    endtask

    // Monitor: pop and compare at every end of conversion.
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_ticks = 0;
            mon_setl  = 0;
        end else begin
            if (adc_tick) mon_ticks++;
            if (settling) mon_setl++;
            if (eoc) begin
                chk(adc_tick, "R6 eoc on last tick", int'(adc_tick), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected eoc", cyc, -1);
                end else begin
                    frame_exp_t it;
                    it = exp_q.pop_front();
                    chk(cyc == it.t, {it.tag, " eoc cycle"}, cyc, it.t);
                    chk(mon_ticks == it.ticks,
                        (it.ticks == 32) ? "R4 ticks per frame" : "R3 ticks per frame",
                        mon_ticks, it.ticks);
                    chk(mon_setl == it.setl, "R5 settling length", mon_setl, it.setl);
                end
                mon_ticks = 0;
                mon_setl  = 0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs low while held in reset
        chk(!(adc_tick || settling || eoc), "R10 reset outputs", int'({adc_tick, settling, eoc}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R3 R7: two default frames back to back at ratio 4
        launch(4, 1'b0);
        push_frame(4, 1'b0, "R1");
        push_frame(4, 1'b0, "R7");
        stop_after_current();
        drain_idle();

        // R2: ratio 0 taken as 2, single-cycle run pulse
        launch(0, 1'b0);
        push_frame(0, 1'b0, "R2");
        stop_after_current();
        drain_idle();

        // R2 R4: ratio 1 taken as 2 with a stretched frame
        launch(1, 1'b1);
        push_frame(1, 1'b1, "R2");
        stop_after_current();
        drain_idle();

        // R8: mid-frame change only applies from the next frame
        launch(3, 1'b0);
        push_frame(3, 1'b0, "R8");
        wait_until(next_t - 60);
        div_ratio   = 8'd5;
        long_settle = 1'b1;
        push_frame(5, 1'b1, "R8");
        push_frame(5, 1'b1, "R7");
        stop_after_current();
        drain_idle();

        // R1 R4: largest ratio with stretched frame
        launch(255, 1'b1);
        push_frame(255, 1'b1, "R1");
        stop_after_current();
        drain_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule